// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block holds thirteen saturating event counters for an Ethernet MAC. Six of them track transmit activity and seven track receive activity. The MAC datapath reports each finished frame with a one-cycle strobe. The strobe carries the frame length in bytes and qualifier flags: frame good, underflow, carrier loss, multicast, CRC error and length error. A separate strobe reports each receive FIFO overflow. From these inputs the bank advances octet counters by the frame length and frame or error counters by one.

Software reaches the bank over a simple single-cycle register bus. A read returns its data in the same cycle as the request. A control register holds two things:
- a self-clearing action that zeroes every counter;
- a mode in which reading a counter also empties it, within that same access.

Each counter has a status flag that sets when the counter's most significant bit becomes set, which is half of its range. Any flag left unmasked by the receive or transmit mask register drives the interrupt output. This lets a driver drain the counters into wider software totals well before they saturate.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter, status flag and mask bit is zero, reset-on-read is off, and `irq` is low.
- R2: Each transmit strobe `tx_done` updates the transmit counters. Octets, good and bad (0x114), add `tx_len`. Frames, good and bad (0x118), add one. Underflow (0x148) adds one when `tx_underflow` is set. Carrier error (0x160) adds one when `tx_carrier_err` is set. Good octets (0x164) add `tx_len` and good frames (0x168) add one, both only when `tx_ok` is set.
- R3: Each receive strobe `rx_done` updates the receive counters. Frames (0x180) add one and octets (0x184) add `rx_len`. Good octets (0x188) add `rx_len` and good multicast (0x190) adds one when `rx_ok` and `rx_mcast` are both set, but good octets needs only `rx_ok`. CRC errors (0x194) add one when `rx_crc_err` is set. Length errors (0x1C8) add one when `rx_len_err` is set. FIFO overflow (0x1D4) adds one on each `rx_fifo_ovf` cycle, independent of `rx_done`.
- R4: A read of a counter address returns the counter's value, zero-extended to 32 bits, in the same cycle. With reset-on-read off, the read leaves the counter unchanged. When no read is requested, `rsp_rdata` is zero.
- R5: Control register bit 2 (offset 0x100) enables reset-on-read. In that mode a counter read returns the current value and the counter restarts at that cycle's increment (zero if none), so no event is lost.
- R6: Writing control bit 0 as one zeroes every counter and status flag at that edge. The clear takes priority over increments and reads in that cycle. The bit always reads back as zero.
- R7: A counter that would pass all ones holds at all ones instead of wrapping.
- R8: A counter's status flag sets when the counter's top bit is set. The flag stays set until that counter is read and its value after the access has the top bit clear. The flags read at 0x104 (receive, bits 0 to 6) and 0x108 (transmit, bits 0 to 5). Bit order follows the counters' address order.
- R9: The receive mask (0x10C, 7 bits) and transmit mask (0x110, 6 bits) use the same bit order as the flags. `irq` is high exactly when some flag is set with its mask bit clear. Bit 27 of the summary register (0x1FC) reads that same pending state.
- R10: Reads of addresses that are not mapped return zero. Writes to counter or status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle as the read |
| tx_done | input | 1 | Transmit frame finished |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_ok | input | 1 | Transmit frame had no error |
| tx_underflow | input | 1 | Transmit frame aborted by underflow |
| tx_carrier_err | input | 1 | Carrier lost during transmit frame |
| rx_done | input | 1 | Receive frame finished |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_ok | input | 1 | Receive frame had no error |
| rx_mcast | input | 1 | Receive frame was multicast |
| rx_crc_err | input | 1 | Receive frame failed CRC |
| rx_len_err | input | 1 | Receive frame length field mismatch |
| rx_fifo_ovf | input | 1 | Receive FIFO overflowed this cycle |
| irq | output | 1 | Unmasked half-range interrupt pending |

## Verification
The hardest states to reach from the ports are the half-range threshold and the saturation ceiling. With 32-bit counters, either one takes billions of events. The bench therefore builds the bank with 12-bit counters and 10-bit frame lengths. A few long frames then carry an octet counter past its top bit and into saturation, while mask changes, reset-on-read accesses and clears land around those points. A long random phase then makes reads and clears coincide with increments, and a behavioural model checks the read data and `irq` on every cycle.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
    localparam int NUM_TX   = 6;
    localparam int NUM_RX   = 7;
    localparam int NUM_CNT  = NUM_TX + NUM_RX;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_RXFLAG  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_TXFLAG  = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_RXMASK  = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_TXMASK  = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_SUMMARY = 12'h1FC;

    localparam int CTRL_CLR_BIT = 0;
    localparam int CTRL_ROR_BIT = 2;
    localparam int SUM_IRQ_BIT  = 27;

    // Counter slots 0..5 are transmit, 6..12 receive, each in address order.
    function automatic logic [ADDR_W-1:0] slot_addr(input int slot);
        case (slot)
            0:       return 12'h114;
            1:       return 12'h118;
            2:       return 12'h148;
            3:       return 12'h160;
            4:       return 12'h164;
            5:       return 12'h168;
            6:       return 12'h180;
            7:       return 12'h184;
            8:       return 12'h188;
            9:       return 12'h190;
            10:      return 12'h194;
            11:      return 12'h1C8;
            default: return 12'h1D4;
        endcase
    endfunction

    typedef struct packed {
        logic              ror;
        logic [NUM_RX-1:0] rx_mask;
        logic [NUM_TX-1:0] tx_mask;
    } cfg_t;
endpackage

// File: rtl/mac_stat_evt_map.sv
module mac_stat_evt_map
    import mac_stat_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic                          tx_done,
    input  logic [LEN_W-1:0]              tx_len,
    input  logic                          tx_ok,
    input  logic                          tx_underflow,
    input  logic                          tx_carrier_err,
    input  logic                          rx_done,
    input  logic [LEN_W-1:0]              rx_len,
    input  logic                          rx_ok,
    input  logic                          rx_mcast,
    input  logic                          rx_crc_err,
    input  logic                          rx_len_err,
    input  logic                          rx_fifo_ovf,
    output logic [NUM_CNT-1:0][LEN_W-1:0] inc_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic tx_good;
    logic rx_good;

    always_comb begin
        tx_good = tx_done & tx_ok;
        rx_good = rx_done & rx_ok;
        inc_o   = '0;
        // transmit slots
        inc_o[0]  = tx_done ? tx_len : '0;
        inc_o[1]  = tx_done ? ONE : '0;
        inc_o[2]  = (tx_done & tx_underflow) ? ONE : '0;
        inc_o[3]  = (tx_done & tx_carrier_err) ? ONE : '0;
        inc_o[4]  = tx_good ? tx_len : '0;
        inc_o[5]  = tx_good ? ONE : '0;
        // receive slots
        inc_o[6]  = rx_done ? ONE : '0;
        inc_o[7]  = rx_done ? rx_len : '0;
        inc_o[8]  = rx_good ? rx_len : '0;
        inc_o[9]  = (rx_good & rx_mcast) ? ONE : '0;
        inc_o[10] = (rx_done & rx_crc_err) ? ONE : '0;
        inc_o[11] = (rx_done & rx_len_err) ? ONE : '0;
        inc_o[12] = rx_fifo_ovf ? ONE : '0;
    end
endmodule

// File: rtl/mac_stat_cnt.sv
module mac_stat_cnt #(
    parameter int CNT_W = 32,
    parameter int INC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             rd_i,
    input  logic             ror_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W:0] base;
    logic [CNT_W:0] sum;

    always_comb begin
        base = (rd_i && ror_i) ? '0 : {1'b0, st_q.cnt};
        sum  = base + (CNT_W+1)'(inc_i);
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else begin
            st_d.cnt  = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
            st_d.flag = st_d.cnt[CNT_W-1] | (st_q.flag & ~rd_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              tx_done,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_ok,
    input  logic              tx_underflow,
    input  logic              tx_carrier_err,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_ok,
    input  logic              rx_mcast,
    input  logic              rx_crc_err,
    input  logic              rx_len_err,
    input  logic              rx_fifo_ovf,
    output logic              irq
);
    cfg_t cfg_d, cfg_q;

    logic                          rd_en;
    logic                          wr_en;
    logic                          clr_pulse;
    logic [NUM_CNT-1:0]            rd_hit;
    logic [NUM_CNT-1:0]            flag_all;
    logic [NUM_CNT*CNT_W-1:0]      cnt_flat;
    logic [NUM_CNT-1:0][LEN_W-1:0] inc_all;
    logic                          ror_now;
    logic [NUM_RX-1:0]             rx_mask_now;
    logic [NUM_TX-1:0]             tx_mask_now;
    logic                          unused_wdata;

    assign rd_en = req_valid & ~req_write;
    assign wr_en = req_valid & req_write;
    assign unused_wdata = ^req_wdata[DATA_W-1:NUM_RX];

    // Configuration next state
    always_comb begin
        cfg_d     = cfg_q;
        clr_pulse = 1'b0;
        if (wr_en) begin
            case (req_addr)
                OFS_CTRL: begin
                    cfg_d.ror = req_wdata[CTRL_ROR_BIT];
                    clr_pulse = req_wdata[CTRL_CLR_BIT];
                end
                OFS_RXMASK: cfg_d.rx_mask = req_wdata[NUM_RX-1:0];
                OFS_TXMASK: cfg_d.tx_mask = req_wdata[NUM_TX-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ror_now     = cfg_q.ror;
    assign rx_mask_now = cfg_q.rx_mask;
    assign tx_mask_now = cfg_q.tx_mask;

    mac_stat_evt_map #(.LEN_W(LEN_W)) u_map (
        .tx_done       (tx_done),
        .tx_len        (tx_len),
        .tx_ok         (tx_ok),
        .tx_underflow  (tx_underflow),
        .tx_carrier_err(tx_carrier_err),
        .rx_done       (rx_done),
        .rx_len        (rx_len),
        .rx_ok         (rx_ok),
        .rx_mcast      (rx_mcast),
        .rx_crc_err    (rx_crc_err),
        .rx_len_err    (rx_len_err),
        .rx_fifo_ovf   (rx_fifo_ovf),
        .inc_o         (inc_all)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assign rd_hit[g] = rd_en && (req_addr == slot_addr(g));
        mac_stat_cnt #(.CNT_W(CNT_W), .INC_W(LEN_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_pulse),
            .rd_i  (rd_hit[g]),
            .ror_i (cfg_q.ror),
            .inc_i (inc_all[g]),
            .cnt_o (cnt_flat[g*CNT_W +: CNT_W]),
            .flag_o(flag_all[g])
        );
    end

    assign irq = (|(flag_all[NUM_TX-1:0] & ~cfg_q.tx_mask))
               | (|(flag_all[NUM_CNT-1:NUM_TX] & ~cfg_q.rx_mask));

    // Read data, same cycle
    always_comb begin
        rsp_rdata = '0;
        if (rd_en) begin
            case (req_addr)
                OFS_CTRL:    rsp_rdata[CTRL_ROR_BIT] = cfg_q.ror;
                OFS_RXFLAG:  rsp_rdata[NUM_RX-1:0] = flag_all[NUM_CNT-1:NUM_TX];
                OFS_TXFLAG:  rsp_rdata[NUM_TX-1:0] = flag_all[NUM_TX-1:0];
                OFS_RXMASK:  rsp_rdata[NUM_RX-1:0] = cfg_q.rx_mask;
                OFS_TXMASK:  rsp_rdata[NUM_TX-1:0] = cfg_q.tx_mask;
                OFS_SUMMARY: rsp_rdata[SUM_IRQ_BIT] = irq;
                default: begin
                    for (int i = 0; i < NUM_CNT; i++) begin
                        if (rd_hit[i]) rsp_rdata = DATA_W'(cnt_flat[i*CNT_W +: CNT_W]);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mac_stat_chk.sv
module mac_stat_chk
    import mac_stat_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     irq,
    input logic                     clr_pulse,
    input logic                     ror_now,
    input logic [NUM_CNT-1:0]       rd_hit,
    input logic [NUM_CNT-1:0]       flag_all,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic [NUM_RX-1:0]        rx_mask_now,
    input logic [NUM_TX-1:0]        tx_mask_now
);
    localparam logic [CNT_W-1:0] TOP = '1;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (cnt_flat == '0 && flag_all == '0)); // R6

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&rx_mask_now && &tx_mask_now) |-> !irq); // R9

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[g*CNT_W +: CNT_W] == TOP && !clr_pulse && !(rd_hit[g] && ror_now))
            |=> cnt_flat[g*CNT_W +: CNT_W] == TOP); // R7

        AST_ROR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit[g] && ror_now && !clr_pulse)
            |=> (cnt_flat[g*CNT_W +: CNT_W] >> LEN_W) == '0); // R5

        AST_PLAIN_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit[g] && !ror_now && !clr_pulse)
            |=> cnt_flat[g*CNT_W +: CNT_W] >= $past(cnt_flat[g*CNT_W +: CNT_W])); // R4

        AST_FLAG_NEEDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_all[g]) |-> cnt_flat[g*CNT_W + CNT_W - 1]); // R8
    end
endmodule

bind mac_stat_bank mac_stat_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .clr_pulse  (clr_pulse),
    .ror_now    (ror_now),
    .rd_hit     (rd_hit),
    .flag_all   (flag_all),
    .cnt_flat   (cnt_flat),
    .rx_mask_now(rx_mask_now),
    .tx_mask_now(tx_mask_now)
);

// File: tb/sim_mac_stat_bank.sv
module sim_mac_stat_bank;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int LW = 10;
    localparam longint MAXV = (longint'(1) << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        tx_done = 0, tx_ok = 0, tx_underflow = 0, tx_carrier_err = 0;
    logic [LW-1:0] tx_len = '0, rx_len = '0;
    logic        rx_done = 0, rx_ok = 0, rx_mcast = 0, rx_crc_err = 0, rx_len_err = 0, rx_fifo_ovf = 0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    longint m_cnt[13];
    bit     m_flag[13];
    bit     m_ror;
    bit [6:0] m_rxm;
    bit [5:0] m_txm;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_stat_bank #(.CNT_W(CW), .LEN_W(LW)) u0 (.*);

    function automatic int m_slot(input logic [11:0] a);
        case (a)
            12'h114: return 0;  12'h118: return 1;  12'h148: return 2;
            12'h160: return 3;  12'h164: return 4;  12'h168: return 5;
            12'h180: return 6;  12'h184: return 7;  12'h188: return 8;
            12'h190: return 9;  12'h194: return 10; 12'h1C8: return 11;
            12'h1D4: return 12;
            default: return -1;
        endcase
    endfunction

    function automatic longint m_inc(input int s);
        case (s)
            0:  return tx_done ? longint'(tx_len) : 0;
            1:  return tx_done ? 1 : 0;
            2:  return (tx_done && tx_underflow) ? 1 : 0;
            3:  return (tx_done && tx_carrier_err) ? 1 : 0;
            4:  return (tx_done && tx_ok) ? longint'(tx_len) : 0;
            5:  return (tx_done && tx_ok) ? 1 : 0;
            6:  return rx_done ? 1 : 0;
            7:  return rx_done ? longint'(rx_len) : 0;
            8:  return (rx_done && rx_ok) ? longint'(rx_len) : 0;
            9:  return (rx_done && rx_ok && rx_mcast) ? 1 : 0;
            10: return (rx_done && rx_crc_err) ? 1 : 0;
            11: return (rx_done && rx_len_err) ? 1 : 0;
            default: return rx_fifo_ovf ? 1 : 0;
        endcase
    endfunction

    function automatic bit m_irq();
        bit r = 0;
        for (int s = 0; s < 13; s++) begin
            bit masked = (s < 6) ? m_txm[s] : m_rxm[s-6];
            if (m_flag[s] && !masked) r = 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] m_read();
        logic [31:0] v = '0;
        int s;
        if (!(req_valid && !req_write)) return '0;
        s = m_slot(req_addr);
        if (s >= 0) return 32'(m_cnt[s]);
        case (req_addr)
            12'h100: v[2] = m_ror;
            12'h104: for (int k = 0; k < 7; k++) v[k] = m_flag[k+6];
            12'h108: for (int k = 0; k < 6; k++) v[k] = m_flag[k];
            12'h10C: v[6:0] = m_rxm;
            12'h110: v[5:0] = m_txm;
            12'h1FC: v[27] = m_irq();
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the settled outputs, then advance the model across the edge.
    task automatic cycle();
        logic [31:0] er;
        bit clr;
        int hs;
        #1;
        er = m_read();
        check(irq === m_irq(), "R9", irq, m_irq());
        if (req_valid && !req_write) check(rsp_rdata === er, tag, rsp_rdata, er);
        else check(rsp_rdata === 32'h0, "R4", rsp_rdata, 0);
        clr = req_valid && req_write && req_addr == 12'h100 && req_wdata[0];
        hs = (req_valid && !req_write) ? m_slot(req_addr) : -1;
        for (int s = 0; s < 13; s++) begin
            longint c;
            if (clr) begin
                m_cnt[s] = 0;
                m_flag[s] = 0;
            end else begin
                c = (s == hs && m_ror) ? 0 : m_cnt[s];
                c = c + m_inc(s);
                if (c > MAXV) c = MAXV;
                m_cnt[s] = c;
                m_flag[s] = c[CW-1] || (m_flag[s] && s != hs);
            end
        end
        if (req_valid && req_write) begin
            case (req_addr)
                12'h100: m_ror = req_wdata[2];
                12'h10C: m_rxm = req_wdata[6:0];
                12'h110: m_txm = req_wdata[5:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle_bus();
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    endtask

    task automatic no_events();
        tx_done = 0; tx_ok = 0; tx_underflow = 0; tx_carrier_err = 0; tx_len = '0;
        rx_done = 0; rx_ok = 0; rx_mcast = 0; rx_crc_err = 0; rx_len_err = 0; rx_len = '0;
        rx_fifo_ovf = 0;
    endtask

    task automatic rd(input logic [11:0] a);
        req_valid = 1; req_write = 0; req_addr = a;
        cycle();
        idle_bus();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        cycle();
        idle_bus();
    endtask

    task automatic txf(input int len, input bit ok, input bit und, input bit car);
        tx_done = 1; tx_len = LW'(len); tx_ok = ok; tx_underflow = und; tx_carrier_err = car;
        cycle();
        no_events();
    endtask

    task automatic rxf(input int len, input bit ok, input bit mc, input bit crc, input bit le);
        rx_done = 1; rx_len = LW'(len); rx_ok = ok; rx_mcast = mc; rx_crc_err = crc; rx_len_err = le;
        cycle();
        no_events();
    endtask

    task automatic read_all();
        for (int s = 0; s < 13; s++) begin
            case (s)
                0: rd(12'h114); 1: rd(12'h118); 2: rd(12'h148); 3: rd(12'h160);
                4: rd(12'h164); 5: rd(12'h168); 6: rd(12'h180); 7: rd(12'h184);
                8: rd(12'h188); 9: rd(12'h190); 10: rd(12'h194); 11: rd(12'h1C8);
                default: rd(12'h1D4);
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 13; s++) begin m_cnt[s] = 0; m_flag[s] = 0; end
        m_ror = 0; m_rxm = '0; m_txm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        tag = "R1";
        read_all();
        rd(12'h100); rd(12'h10C); rd(12'h110); rd(12'h104); rd(12'h108);
        // R2: transmit counters
        tag = "R2";
        txf(64, 1, 0, 0); txf(100, 0, 1, 0); txf(77, 0, 0, 1); txf(9, 1, 0, 0);
        read_all();
        // R3: receive counters, including stray qualifiers without rx_done
        tag = "R3";
        rxf(60, 1, 1, 0, 0); rxf(61, 1, 0, 0, 0); rxf(70, 0, 0, 1, 0); rxf(80, 0, 0, 0, 1);
        rx_fifo_ovf = 1; rx_ok = 1; rx_mcast = 1; cycle(); no_events();
        read_all();
        // R4: plain reads keep value
        tag = "R4";
        rd(12'h118); rd(12'h118);
        // R10: unmapped read and ignored counter write
        tag = "R10";
        rd(12'h120); wr(12'h118, 32'hFFF); wr(12'h104, 32'h7F); rd(12'h118); rd(12'h104);
        // R5: reset-on-read, with and without simultaneous increment
        tag = "R5";
        wr(12'h100, 32'h4); rd(12'h100);
        rd(12'h114); rd(12'h114);
        tx_done = 1; tx_len = LW'(33); tx_ok = 1; req_valid = 1; req_addr = 12'h114;
        cycle(); idle_bus(); no_events();
        rd(12'h114);
        // R6: clear-all beats a same-cycle increment
        tag = "R6";
        txf(200, 1, 0, 0);
        rx_done = 1; rx_len = LW'(50); tx_done = 1; tx_len = LW'(5);
        req_valid = 1; req_write = 1; req_addr = 12'h100; req_wdata = 32'h1;
        cycle(); idle_bus(); no_events();
        rd(12'h100);
        read_all();
        // R8, R9: cross half range on transmit octets
        tag = "R8";
        txf(1000, 1, 0, 0); txf(1000, 1, 0, 0); rd(12'h108);
        txf(1000, 1, 0, 0); rd(12'h108); rd(12'h1FC);
        tag = "R9";
        wr(12'h110, 32'h3F); rd(12'h1FC); wr(12'h110, 32'h0); rd(12'h1FC);
        wr(12'h10C, 32'h7F); rd(12'h10C);
        // R7: saturate receive octets (mode still plain from the clear write)
        tag = "R7";
        for (int k = 0; k < 6; k++) rxf(1023, 1, 0, 0, 0);
        rd(12'h184); rd(12'h188); rxf(500, 0, 0, 0, 0); rd(12'h184);
        // R8: flag held through plain read, cleared by emptying read
        tag = "R8";
        rd(12'h104); wr(12'h100, 32'h4); rd(12'h184); rd(12'h104);
        rd(12'h114); rd(12'h108); rd(12'h1FC);
        // random mix
        tag = "R5";
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            tx_done = $urandom_range(0, 2) == 0; tx_len = LW'($urandom);
            tx_ok = $urandom_range(0, 1); tx_underflow = $urandom_range(0, 3) == 0;
            tx_carrier_err = $urandom_range(0, 3) == 0;
            rx_done = $urandom_range(0, 2) == 0; rx_len = LW'($urandom);
            rx_ok = $urandom_range(0, 1); rx_mcast = $urandom_range(0, 1);
            rx_crc_err = $urandom_range(0, 3) == 0; rx_len_err = $urandom_range(0, 3) == 0;
            rx_fifo_ovf = $urandom_range(0, 4) == 0;
            if (r < 40) begin
                req_valid = 1; req_write = 0;
                req_addr = (r < 35) ? 12'h114 + 12'($urandom_range(0, 48) * 4) : 12'h1FC;
            end else if (r < 44) begin
                req_valid = 1; req_write = 1; req_addr = 12'h100;
                req_wdata = {29'h0, 1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 9) == 0)};
            end else if (r < 48) begin
                req_valid = 1; req_write = 1;
                req_addr = (r < 46) ? 12'h10C : 12'h110; req_wdata = $urandom;
            end else begin
                idle_bus();
            end
            cycle();
        end
        idle_bus(); no_events();
        tag = "R4";
        read_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule